// File: doc/BRIEF.md
# Set/Clear GPIO Port

The block is a general-purpose I/O port with a parameterised number of lines (up to 32) behind a small word-indexed register interface. Software never writes the output latches directly. It raises lines through a write-one-to-set register and lowers them through a write-one-to-clear register. A single store therefore changes only the chosen bits, and no read-modify-write sequence is needed when several agents share the port.

A read/write direction register selects, line by line, whether the port drives the pin. A read-only pin-state register returns the level of every line after a two-flop synchronizer. The physical pad is not part of the block. It is represented by three vectors: the driven value, the output enable and the sampled input.

The register index on `bus_addr` is a word index. Index 0 is byte offset 0x0, index 1 is 0x4, index 2 is 0x8 and index 3 is 0xC. Bit n of every register belongs to line n.

Top module: `gpio_setclr_port`

## Requirements
- R1: A write to index 0 (clear) forces output latch n to 0 for every bit n written as 1. Latch bits written as 0 keep their value. The change is visible on `gpio_out` after the write's clock edge.
- R2: A write to index 1 (set) forces output latch n to 1 for every bit n written as 1. Latch bits written as 0 keep their value. The change is visible on `gpio_out` after the write's clock edge.
- R3: Index 2 (direction) stores the written word after the write's clock edge, and reading index 2 returns it. A 1 in bit n makes line n an output, and `gpio_oe[n]` equals direction bit n.
- R4: `gpio_out[n]` always carries output latch n, whatever the direction of line n.
- R5: Reading index 3 (pin state) returns `gpio_in` as sampled through two flops. A change on the input is visible after the second rising clock edge that follows it, and not after the first.
- R6: Reads of index 0 and index 1 return all zeros.
- R7: After reset all direction bits are 0, so every line is an input, and all output latches are 0.
- R8: A write to index 3 has no effect on the output latches or on the direction register.
- R9: With no write strobe, the output latches and the direction register hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data for `bus_addr`, combinational |
| gpio_in | input | NLINES | Sampled pin levels |
| gpio_out | output | NLINES | Driven pin values |
| gpio_oe | output | NLINES | Per-line output enable |

## Verification
The assertions assume that `bus_wr` and `bus_addr` are stable around each rising edge. They also assume that `gpio_in` changes at most once between two edges, so that the synchronizer relation holds at the sampling edge. The bench meets both conditions by changing every input only on the falling edge.

The assertions also treat `bus_rdata` as a pure function of the current index and state, with no read strobe. The bench therefore checks reads combinationally, shortly after it sets the index.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int REG_IDX_W = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_CLR = 2'd0,
        REG_SET = 2'd1,
        REG_DIR = 2'd2,
        REG_PIN = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;

    // R5
    sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out == $past(st_q.stage1));
endmodule

// File: rtl/gpio_latch_bank.sv
module gpio_latch_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < W; i++) begin
            if (set_we && wdata[i]) bk_d.latch[i] = 1'b1;
            if (clr_we && wdata[i]) bk_d.latch[i] = 1'b0;
        end
        if (dir_we) bk_d.dir = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign latch_q = bk_q.latch;
    assign dir_q   = bk_q.dir;

    // R1
    clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> latch_q == ($past(latch_q) & ~$past(wdata)));
    // R2
    set_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> latch_q == ($past(latch_q) | $past(wdata)));
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(latch_q));
    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we |=> $stable(dir_q));
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic [NLINES-1:0]    bus_wdata,
    output logic [NLINES-1:0]    bus_rdata,
    input  logic [NLINES-1:0]    gpio_in,
    output logic [NLINES-1:0]    gpio_out,
    output logic [NLINES-1:0]    gpio_oe
);
    reg_sel_e          sel;
    logic              set_we, clr_we, dir_we;
    logic [NLINES-1:0] latch_q, dir_q, pins_q;

    assign sel    = reg_sel_e'(bus_addr);
    assign set_we = bus_wr && (sel == REG_SET);
    assign clr_we = bus_wr && (sel == REG_CLR);
    assign dir_we = bus_wr && (sel == REG_DIR);

    gpio_latch_bank #(.W(NLINES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (set_we),
        .clr_we  (clr_we),
        .dir_we  (dir_we),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_sync2 #(.W(NLINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gpio_in),
        .sync_out (pins_q)
    );

    always_comb begin
        unique case (sel)
            REG_DIR: bus_rdata = dir_q;
            REG_PIN: bus_rdata = pins_q;
            default: bus_rdata = '0;
        endcase
    end

    assign gpio_out = latch_q;
    assign gpio_oe  = dir_q;

    // R6
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CLR || bus_addr == REG_SET) |-> bus_rdata == '0);
    // R3
    dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_DIR) |-> bus_rdata == gpio_oe);
    // R8
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_PIN) |=> ($stable(gpio_out) && $stable(gpio_oe)));
    // R3
    dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIR) |=> gpio_oe == $past(bus_wdata));
endmodule

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] gpio_in = '0;
    logic [N-1:0] gpio_out, gpio_oe;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] exp_out = '0;
    logic [N-1:0] exp_dir = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_setclr_port #(.NLINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic [N-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 out", gpio_out, '0);
        check("R7 oe", gpio_oe, '0);
        bus_read(2'd2, rd); check("R7 dir", rd, '0);

        // R2 / R1 sweeps with R4 (direction all inputs)
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd1, N'(v));
            exp_out = exp_out | N'(v);
            check("R2 set", gpio_out, exp_out);
            bus_write(2'd0, N'(v * 37 + 5));
            exp_out = exp_out & ~N'(v * 37 + 5);
            check("R1 clr", gpio_out, exp_out);
            check("R4 out independent of dir", gpio_oe, '0);
        end

        // R3 direction sweep, R8 pin writes ignored, R6 zero reads
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd2, N'(v));
            exp_dir = N'(v);
            check("R3 oe", gpio_oe, exp_dir);
            bus_read(2'd2, rd); check("R3 readback", rd, exp_dir);
            bus_write(2'd3, ~N'(v));
            check("R8 out", gpio_out, exp_out);
            check("R8 oe", gpio_oe, exp_dir);
            bus_read(2'd0, rd); check("R6 clr read", rd, '0);
            bus_read(2'd1, rd); check("R6 set read", rd, '0);
            bus_write(2'd1, N'(v ^ 8'h5a));
            exp_out = exp_out | N'(v ^ 8'h5a);
            check("R4 out with dir", gpio_out, exp_out);
        end

        // R9 idle holds
        repeat (5) @(negedge clk);
        check("R9 out hold", gpio_out, exp_out);
        check("R9 oe hold", gpio_oe, exp_dir);

        // R5 pin-state sweep with two-edge latency
        bus_addr = 2'd3;
        @(negedge clk); @(negedge clk);
        for (int v = 1; v < 256; v++) begin
            logic [N-1:0] prev;
            prev = gpio_in;
            gpio_in = N'(v);
            @(negedge clk);
            bus_read(2'd3, rd); check("R5 one edge", rd, prev);
            @(negedge clk);
            bus_read(2'd3, rd); check("R5 two edges", rd, N'(v));
        end

        // R7 reset again clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 out after reset", gpio_out, '0);
        check("R7 oe after reset", gpio_oe, '0);
        rst_n = 1'b1;
        report();
    end
endmodule